// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a serial nonvolatile memory and decides, request by request, whether a write into the storage array or into the status register itself may go ahead. A serial front end hands it decoded commands: a write-enable command, a status-write request with its data byte, and an array-write request with the target address. The block answers with a single-cycle permit pulse for whichever write it accepts. It also reports the status byte that a status-read command shifts out.

Two fields set the protection. A two-bit lock code selects how much of the top of the array is read-only. A pin-enable bit chooses between two modes. In software mode the write-protect pin has no effect. In hardware mode, driving the active-low pin low freezes the status register, while array areas outside the locked range stay writable. Every write also needs the enable latch to be set beforehand. A status write loads its new lock and pin-enable bits into the register only when its internal programming delay ends, and the write-in-progress flag stays high for that whole delay. The flag also follows a busy signal from the array during array programming.

Top module: `sr_guard`

## Requirements
- R1: While reset is high and right after it, the status byte reads 0x00 and both permit outputs are low. At most one permit is high in any cycle.
- R2: A write-enable command sets status bit 1 (the enable latch) one cycle later. Each accepted write clears the latch in the same cycle its permit rises.
- R3: When bit 1 is clear, array-write and status-write requests give no permit and leave the status byte unchanged.
- R4: The lock code in status bits 3:2 protects these addresses: 00 none, 01 the top quarter, 10 the top half, 11 the whole array. An array write to a protected address gives no permit and leaves bit 1 set. A write to an unprotected address is permitted one cycle after the request.
- R5: With pin-enable (status bit 7) at 0, the write-protect pin has no effect. Status writes are accepted, and array protection follows R4 alone.
- R6: With bit 7 at 1 and the write-protect pin high, behaviour is the same as in R5.
- R7: With bit 7 at 1 and the write-protect pin low, a status write gives no permit and leaves the byte unchanged. Protected addresses stay blocked and unprotected addresses stay writable.
- R8: Status bit 0 (write in progress) reads high for exactly PROG_CYCLES cycles, starting in the cycle the status-write permit rises. It also reads high in every cycle that the array busy input is high.
- R9: An accepted status write changes bits 7 and 3:2 only in the cycle bit 0 falls. Data bits 0, 1, 4, 5 and 6 have no effect, and status bits 6:4 always read 0.
- R10: While bit 0 is high, array-write and status-write requests give no permit.
- R11: When a status-write request and an array-write request arrive in the same cycle, only the status write is considered. The array request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_cmd | input | 1 | Write-enable command pulse |
| wrsr_req | input | 1 | Status-write request pulse |
| wrsr_data | input | 8 | Data byte for the status write |
| arr_req | input | 1 | Array-write request pulse |
| arr_addr | input | ADDR_W | Target address of the array write |
| arr_busy | input | 1 | High while the array is programming |
| status_byte | output | 8 | Status byte for status reads |
| arr_permit | output | 1 | One-cycle grant for an array write |
| sr_permit | output | 1 | One-cycle grant for a status write |
| wel | output | 1 | State of the enable latch |

## Verification
Requests and commands are applied on one falling edge. The bench samples the permits and the enable latch on the next falling edge, because one register stage lies between a request and its result. The write-in-progress flag is counted on falling edges, starting at the edge where the permit is first seen, and the count must equal PROG_CYCLES. The new lock and pin-enable values are checked at the first sample after the flag falls, and the old values at the first sample after the permit. The busy input feeds bit 0 with no register in between, so its effect is sampled on the same falling edge at which the input is driven.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int WIP_BIT = 0;
  localparam int WEL_BIT = 1;
  localparam int LOCK_LO = 2;
  localparam int LOCK_HI = 3;
  localparam int PEN_BIT = 7;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_e;

  function automatic logic [7:0] pack_status(input logic pen, input lock_e lock,
                                             input logic wel, input logic wip);
    logic [7:0] s;
    s = 8'h00;
    s[PEN_BIT] = pen;
    s[LOCK_HI:LOCK_LO] = lock;
    s[WEL_BIT] = wel;
    s[WIP_BIT] = wip;
    return s;
  endfunction
endpackage

// File: rtl/srg_region.sv
module srg_region
  import srg_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  lock_e             lock,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (lock)
      LOCK_NONE: prot = 1'b0;
      LOCK_QTR:  prot = addr[TOP] & addr[TOP-1];
      LOCK_HALF: prot = addr[TOP];
      default:   prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/srg_timer.sv
module srg_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= LOAD;
    else if (busy)  cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/srg_nvbits.sv
module srg_nvbits
  import srg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic [7:0] data,
  input  logic       commit,
  output logic       pen,
  output lock_e      lock
);
  logic  pen_pend;
  lock_e lock_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pen       <= 1'b0;
      lock      <= LOCK_NONE;
      pen_pend  <= 1'b0;
      lock_pend <= LOCK_NONE;
    end else begin
      if (capture) begin
        pen_pend  <= data[PEN_BIT];
        lock_pend <= lock_e'(data[LOCK_HI:LOCK_LO]);
      end
      if (commit) begin
        pen  <= pen_pend;
        lock <= lock_pend;
      end
    end
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import srg_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PROG_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic              wren_cmd,
  input  logic              wrsr_req,
  input  logic [7:0]        wrsr_data,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_busy,
  output logic [7:0]        status_byte,
  output logic              arr_permit,
  output logic              sr_permit,
  output logic              wel
);
  logic  pen, prot, tmr_busy, tmr_done, wip, hw_lock, sr_ok, arr_ok;
  lock_e lock;

  srg_region #(.ADDR_W(ADDR_W)) u_region (
    .lock(lock), .addr(arr_addr), .prot(prot)
  );

  srg_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(sr_ok), .busy(tmr_busy), .done(tmr_done)
  );

  srg_nvbits u_nv (
    .clk(clk), .rst(rst), .capture(sr_ok), .data(wrsr_data),
    .commit(tmr_done), .pen(pen), .lock(lock)
  );

  assign wip     = tmr_busy | arr_busy;
  assign hw_lock = pen & ~wp_n;
  assign sr_ok   = wrsr_req & wel & ~wip & ~hw_lock;
  assign arr_ok  = arr_req & ~wrsr_req & wel & ~wip & ~prot;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel        <= 1'b0;
      arr_permit <= 1'b0;
      sr_permit  <= 1'b0;
    end else begin
      arr_permit <= arr_ok;
      sr_permit  <= sr_ok;
      if (sr_ok || arr_ok) wel <= 1'b0;
      else if (wren_cmd)   wel <= 1'b1;
    end
  end

  assign status_byte = pack_status(pen, lock, wel, wip);
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       wp_n,
  input logic [7:0] status_byte,
  input logic       arr_permit,
  input logic       sr_permit
);
  a_r1_single_permit: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arr_permit, sr_permit}));

  a_r3_permit_needs_wel: assert property (@(posedge clk) disable iff (rst)
    (arr_permit || sr_permit) |-> $past(status_byte[1]));

  a_r2_accept_clears_wel: assert property (@(posedge clk) disable iff (rst)
    (arr_permit || sr_permit) |-> !status_byte[1]);

  a_r7_hw_freeze: assert property (@(posedge clk) disable iff (rst)
    sr_permit |-> !($past(status_byte[7]) && !$past(wp_n)));

  a_r8_wip_on_accept: assert property (@(posedge clk) disable iff (rst)
    sr_permit |-> status_byte[0]);

  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    (arr_permit || sr_permit) |-> !$past(status_byte[0]));

  a_r9_commit_at_end: assert property (@(posedge clk) disable iff (rst)
    (status_byte[7:2] != $past(status_byte[7:2])) |-> $past(status_byte[0]));
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk(clk), .rst(rst), .wp_n(wp_n), .status_byte(status_byte),
  .arr_permit(arr_permit), .sr_permit(sr_permit)
);

// File: tb/sr_guard_test.sv
module sr_guard_test;
  localparam int AW = 15;
  localparam int PC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wp_n = 1'b1, wren_cmd = 1'b0, wrsr_req = 1'b0, arr_req = 1'b0, arr_busy = 1'b0;
  logic [7:0]    wrsr_data = 8'h00;
  logic [AW-1:0] arr_addr = '0;
  logic [7:0]    status_byte;
  logic          arr_permit, sr_permit, wel;
  int            n_chk = 0, n_fail = 0;

  sr_guard #(.ADDR_W(AW), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .wren_cmd(wren_cmd), .wrsr_req(wrsr_req),
    .wrsr_data(wrsr_data), .arr_req(arr_req), .arr_addr(arr_addr), .arr_busy(arr_busy),
    .status_byte(status_byte), .arr_permit(arr_permit), .sr_permit(sr_permit), .wel(wel)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wren();
    @(negedge clk) wren_cmd = 1'b1;
    @(negedge clk) wren_cmd = 1'b0;
  endtask

  // request an array write; returns the permit seen one cycle later
  task automatic do_arr(input logic [AW-1:0] a, output logic p);
    @(negedge clk) begin arr_req = 1'b1; arr_addr = a; end
    @(negedge clk) begin p = arr_permit; arr_req = 1'b0; end
  endtask

  task automatic do_wrsr(input logic [7:0] d, output logic p);
    @(negedge clk) begin wrsr_req = 1'b1; wrsr_data = d; end
    @(negedge clk) begin p = sr_permit; wrsr_req = 1'b0; end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status_byte[0] && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic set_sr(input logic [7:0] d);
    logic p; int n;
    do_wren();
    do_wrsr(d, p);
    wait_idle(n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 status in reset", status_byte, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", status_byte, 8'h00);
    chk("R1 permits after reset", {arr_permit, sr_permit}, 2'b00);
  endtask

  task automatic t_no_wel();
    logic p;
    do_arr(15'h0000, p);
    chk("R3 array permit without latch", p, 1'b0);
    do_wrsr(8'h8C, p);
    chk("R3 status permit without latch", p, 1'b0);
    repeat (PC + 1) @(negedge clk);
    chk("R3 status unchanged", status_byte, 8'h00);
  endtask

  task automatic t_wren();
    logic p;
    do_wren();
    chk("R2 latch set", status_byte, 8'h02);
    chk("R2 wel port", wel, 1'b1);
    do_arr(15'h1234, p);
    chk("R2 array permit", p, 1'b1);
    chk("R2 latch cleared by accept", status_byte[1], 1'b0);
  endtask

  task automatic t_wip_and_dontcare();
    logic p; int n;
    do_wren();
    do_wrsr(8'h7F, p);
    chk("R5 status write accepted", p, 1'b1);
    chk("R9 old bits during cycle", status_byte, 8'h01);
    wait_idle(n);
    chk("R8 wip length", n, PC);
    chk("R9 bits committed, dont-care ignored", status_byte, 8'h0C);
    set_sr(8'h00);
    chk("R9 cleared", status_byte, 8'h00);
  endtask

  task automatic lock_case(input logic [7:0] d, input logic [AW-1:0] a, input logic exp, input string req);
    logic p;
    set_sr(d);
    do_wren();
    do_arr(a, p);
    chk(req, p, exp);
    chk({req, " latch"}, status_byte[1], !exp);
  endtask

  task automatic t_lock_map();
    lock_case(8'h00, 15'h7FFF, 1'b1, "R4 none top");
    lock_case(8'h04, 15'h5FFF, 1'b1, "R4 quarter below");
    lock_case(8'h04, 15'h6000, 1'b0, "R4 quarter edge");
    lock_case(8'h08, 15'h3FFF, 1'b1, "R4 half below");
    lock_case(8'h08, 15'h4000, 1'b0, "R4 half edge");
    lock_case(8'h0C, 15'h0000, 1'b0, "R4 all low");
    wp_n = 1'b0;
    lock_case(8'h04, 15'h7000, 1'b0, "R5 pin ignored, protected");
    set_sr(8'h00);
    chk("R5 pin low, status writable", status_byte, 8'h00);
    wp_n = 1'b1;
  endtask

  task automatic t_hw_mode();
    logic p; int n;
    set_sr(8'h84);
    chk("R6 pen set with pin high", status_byte, 8'h84);
    lock_case(8'h84, 15'h7FFF, 1'b0, "R6 protected with pin high");
    set_sr(8'h84);
    do_wren();
    do_arr(15'h0010, p);
    chk("R6 unprotected with pin high", p, 1'b1);
    wp_n = 1'b0;
    do_wren();
    do_wrsr(8'h00, p);
    chk("R7 status write blocked", p, 1'b0);
    repeat (PC + 1) @(negedge clk);
    chk("R7 status frozen", status_byte, 8'h86);
    do_arr(15'h7FFF, p);
    chk("R7 protected blocked", p, 1'b0);
    do_arr(15'h0000, p);
    chk("R7 unprotected writable", p, 1'b1);
    wp_n = 1'b1;
    set_sr(8'h00);
    chk("R6 status writable again", status_byte, 8'h00);
  endtask

  task automatic t_busy();
    logic p; int n;
    @(negedge clk) arr_busy = 1'b1;
    #1 chk("R8 wip follows array busy", status_byte[0], 1'b1);
    do_wren();
    do_arr(15'h0000, p);
    chk("R10 array blocked when busy", p, 1'b0);
    do_wrsr(8'h0C, p);
    chk("R10 status blocked when busy", p, 1'b0);
    @(negedge clk) arr_busy = 1'b0;
    #1 chk("R8 wip clears", status_byte, 8'h02);
    do_wrsr(8'h00, p);
    do_wren();
    do_arr(15'h0000, p);
    chk("R10 array blocked during status cycle", p, 1'b0);
    wait_idle(n);
  endtask

  task automatic t_both();
    logic p;
    do_wren();
    @(negedge clk) begin wrsr_req = 1'b1; wrsr_data = 8'h08; arr_req = 1'b1; arr_addr = '0; end
    @(negedge clk) begin
      chk("R11 status wins", sr_permit, 1'b1);
      chk("R11 array dropped", arr_permit, 1'b0);
      wrsr_req = 1'b0; arr_req = 1'b0;
    end
    begin int n; wait_idle(n); end
    chk("R11 status committed", status_byte, 8'h08);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_no_wel();
    t_wren();
    t_wip_and_dontcare();
    t_lock_map();
    t_hw_mode();
    t_busy();
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule